// File: doc/BRIEF.md
# Quad-Word Program Sequence Collector

This block sits on the write side of a flash-style command interface. It watches single-cycle write strobes. Each strobe carries a 24-bit address and a 16-bit data word. When a write carries the quad-program command code, the block gathers the next four writes as address/data pairs. When a write carries the single-program command code, it gathers only the next write. When a sequence completes, the block hands the captured bundle and a word count to a downstream program engine through a request/acknowledge handshake.

A quad sequence is valid only when all four addresses fall in the same aligned four-word group, meaning every address bit above the two lowest matches. A write whose address leaves the group of the first captured word ends the sequence at once. In that case no request is raised and the block goes back to idle. Once a request has been raised, the block reports busy and disregards all writes until the engine signals completion.

Top module: `qwp_collector`

## Requirements
- R1: After reset, `progReq` and `busy` are low, `progCount` is 0, and every bit of `progAddr` and `progData` is 0.
- R2: In idle, a write whose data low byte is A5h starts a quad sequence. The upper data byte is ignored. The next four writes are stored in order in slots 0..3, where slot i occupies `progAddr[i*24 +: 24]` and `progData[i*16 +: 16]`. `progReq` is high from the clock cycle after the fourth write, and `progCount` is 4.
- R3: In idle, a write whose data low byte is A0h starts a single-word program. The next write is stored in slot 0, slots 1..3 read as 0, `progReq` rises in the cycle after that write, and `progCount` is 1.
- R4: During a quad sequence, a write whose address bits 23..2 differ from those of slot 0 aborts the sequence. No request is raised and the block returns to idle. Address bits 1..0 may take any values, including repeated ones.
- R5: While `progReq` is high and `progAck` is low, `progReq`, `progCount` and the bundle stay unchanged. A cycle with `progAck` high ends the request.
- R6: `busy` is high from the first cycle of `progReq` until the cycle after `progDone` is seen following the acknowledge. Writes during that time, including command codes, change neither the bundle nor the state.
- R7: In idle, writes with any other low byte are ignored, as are `progAck` and `progDone`.
- R8: A `progDone` pulse while the request is still waiting for its acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wePulse | input | 1 | One-cycle write strobe |
| weAddr | input | 24 | Write address |
| weData | input | 16 | Write data |
| progReq | output | 1 | Program request to the engine |
| progAck | input | 1 | Engine accepts the request |
| progDone | input | 1 | Engine finished programming |
| busy | output | 1 | Program operation pending or running |
| progCount | output | 3 | Number of valid words in the bundle (0, 1 or 4) |
| progAddr | output | 96 | Four captured addresses, slot 0 in the low bits |
| progData | output | 64 | Four captured data words, slot 0 in the low bits |

## Verification
The bench builds the block with its default parameters: four words per group, 24-bit addresses and 16-bit data. This keeps the group boundary at address bit 2 and makes every upper address bit reachable. The bench sweeps an abort over each of the 22 group bits at each of the three later word positions. It also runs quad sequences whose low address bits are permuted or repeated, and it checks single-word programs, command bytes with varied upper bytes, and writes, acknowledges and completions issued at the wrong time.

// File: rtl/qwp_pkg.sv
package qwp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FILL, ST_REQ, ST_WAIT} qwpState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;   // empty all slots, rewind the write pointer
    logic load;  // store the current write in the pointed slot, advance
  } qwpStrobe_t;
endpackage

// File: rtl/qwp_datapath.sv
module qwp_datapath
  import qwp_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  qwpStrobe_t               strobe,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic                     groupOk,
  output logic                     atLast,
  output logic [WORDS*ADDR_W-1:0]  slotAddr,
  output logic [WORDS*DATA_W-1:0]  slotData
);
  localparam int PTR_W   = $clog2(WORDS);
  localparam int GRP_LSB = PTR_W;

  logic [PTR_W-1:0]  wrPtr;
  logic [ADDR_W-1:0] addrQ [WORDS];
  logic [DATA_W-1:0] dataQ [WORDS];

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clr) wrPtr <= '0;
    else if (strobe.load)    wrPtr <= wrPtr + 1'b1;
  end

  for (genvar i = 0; i < WORDS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN || strobe.clr) begin
        addrQ[i] <= '0;
        dataQ[i] <= '0;
      end else if (strobe.load && wrPtr == PTR_W'(i)) begin
        addrQ[i] <= wrAddr;
        dataQ[i] <= wrData;
      end
    end
    assign slotAddr[i*ADDR_W +: ADDR_W] = addrQ[i];
    assign slotData[i*DATA_W +: DATA_W] = dataQ[i];
  end

  assign atLast  = (wrPtr == PTR_W'(WORDS-1));
  assign groupOk = (wrPtr == '0) ||
                   (wrAddr[ADDR_W-1:GRP_LSB] == addrQ[0][ADDR_W-1:GRP_LSB]);

  // R4: control never stores a word outside the group of slot 0
  assert_load_in_group_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && wrPtr != '0) |->
      (wrAddr[ADDR_W-1:GRP_LSB] == addrQ[0][ADDR_W-1:GRP_LSB]));

  // R2: a cleared bundle starts at slot 0
  assert_clr_rewinds_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clr |=> (wrPtr == '0));
endmodule

// File: rtl/qwp_ctrl.sv
module qwp_ctrl
  import qwp_pkg::*;
#(
  parameter int         WORDS      = 4,
  parameter logic [7:0] CMD_QUAD   = 8'hA5,
  parameter logic [7:0] CMD_SINGLE = 8'hA0,
  localparam int        CNT_W      = $clog2(WORDS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wePulse,
  input  logic [7:0]       cmdByte,
  input  logic             groupOk,
  input  logic             atLast,
  input  logic             progAck,
  input  logic             progDone,
  output qwpStrobe_t       strobe,
  output logic             progReq,
  output logic             busy,
  output logic [CNT_W-1:0] progCount
);
  qwpState_e state, stateNext;
  logic      isQuad, isQuadNext;

  always_comb begin
    stateNext  = state;
    isQuadNext = isQuad;
    strobe     = '0;
    unique case (state)
      ST_IDLE: if (wePulse) begin
        if (cmdByte == CMD_QUAD) begin
          strobe.clr = 1'b1;
          isQuadNext = 1'b1;
          stateNext  = ST_FILL;
        end else if (cmdByte == CMD_SINGLE) begin
          strobe.clr = 1'b1;
          isQuadNext = 1'b0;
          stateNext  = ST_FILL;
        end
      end
      ST_FILL: if (wePulse) begin
        if (groupOk) begin
          strobe.load = 1'b1;
          if (!isQuad || atLast) stateNext = ST_REQ;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_REQ:  if (progAck)  stateNext = ST_WAIT;
      ST_WAIT: if (progDone) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isQuad <= 1'b0;
    end else begin
      state  <= stateNext;
      isQuad <= isQuadNext;
    end
  end

  assign progReq   = (state == ST_REQ);
  assign busy      = (state == ST_REQ) || (state == ST_WAIT);
  assign progCount = !busy ? '0 : (isQuad ? CNT_W'(WORDS) : CNT_W'(1));

  // R5: an unacknowledged request is held
  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (progReq && !progAck) |=> progReq);

  // R6: busy only drops after a completion
  assert_busy_until_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !progDone) |=> busy);

  // R6: nothing is captured while busy
  assert_no_capture_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!strobe.load && !strobe.clr));

  // R2: a request only follows a write strobe
  assert_req_after_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progReq) |-> $past(wePulse));
endmodule

// File: rtl/qwp_collector.sv
module qwp_collector
  import qwp_pkg::*;
#(
  parameter int         ADDR_W     = 24,
  parameter int         DATA_W     = 16,
  parameter int         WORDS      = 4,
  parameter logic [7:0] CMD_QUAD   = 8'hA5,
  parameter logic [7:0] CMD_SINGLE = 8'hA0,
  localparam int        CNT_W      = $clog2(WORDS + 1),
  localparam int        GRP_LSB    = $clog2(WORDS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wePulse,
  input  logic [ADDR_W-1:0]       weAddr,
  input  logic [DATA_W-1:0]       weData,
  output logic                    progReq,
  input  logic                    progAck,
  input  logic                    progDone,
  output logic                    busy,
  output logic [CNT_W-1:0]        progCount,
  output logic [WORDS*ADDR_W-1:0] progAddr,
  output logic [WORDS*DATA_W-1:0] progData
);
  qwpStrobe_t strobe;
  logic       groupOk, atLast;

  qwp_ctrl #(
    .WORDS(WORDS), .CMD_QUAD(CMD_QUAD), .CMD_SINGLE(CMD_SINGLE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wePulse(wePulse), .cmdByte(weData[7:0]),
    .groupOk(groupOk), .atLast(atLast), .progAck(progAck),
    .progDone(progDone), .strobe(strobe), .progReq(progReq),
    .busy(busy), .progCount(progCount)
  );

  qwp_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(weAddr),
    .wrData(weData), .groupOk(groupOk), .atLast(atLast),
    .slotAddr(progAddr), .slotData(progData)
  );

  // R5: the bundle is stable while a request waits
  assert_bundle_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (progReq && !progAck) |=> ($stable(progAddr) && $stable(progData)
                               && $stable(progCount)));

  // R4: a full-size request only carries one address group
  for (genvar i = 1; i < WORDS; i++) begin : g_grp_chk
    assert_req_one_group_R4: assert property (@(posedge clk) disable iff (!rstN)
      (progReq && progCount == CNT_W'(WORDS)) |->
        (progAddr[i*ADDR_W+GRP_LSB +: ADDR_W-GRP_LSB] ==
         progAddr[GRP_LSB +: ADDR_W-GRP_LSB]));
  end
endmodule

// File: tb/tb_qwp_collector.sv
`timescale 1ns/1ps
module tb_qwp_collector;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wePulse = 1'b0;
  logic [23:0] weAddr = '0;
  logic [15:0] weData = '0;
  logic        progAck = 1'b0, progDone = 1'b0;
  logic        progReq, busy;
  logic [2:0]  progCount;
  logic [95:0] progAddr;
  logic [63:0] progData;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  qwp_collector dut (
    .clk(clk), .rstN(rstN), .wePulse(wePulse), .weAddr(weAddr),
    .weData(weData), .progReq(progReq), .progAck(progAck),
    .progDone(progDone), .busy(busy), .progCount(progCount),
    .progAddr(progAddr), .progData(progData)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // inputs change at negedge; one write strobe lasts one cycle
  task automatic wr(input logic [23:0] a, input logic [15:0] d);
    wePulse = 1'b1; weAddr = a; weData = d;
    @(negedge clk);
    wePulse = 1'b0;
  endtask

  task automatic pulseAck();
    progAck = 1'b1; @(negedge clk); progAck = 1'b0;
  endtask

  task automatic pulseDone();
    progDone = 1'b1; @(negedge clk); progDone = 1'b0;
  endtask

  task automatic finishReq();
    pulseAck();
    pulseDone();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [23:0] expA [4];
    logic [15:0] expD [4];
    logic [23:0] base;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 progReq", progReq, 0);
    chk("R1 busy", busy, 0);
    chk("R1 progCount", progCount, 0);
    chk("R1 progAddr", progAddr, 0);
    chk("R1 progData", progData, 0);

    // R7 other data ignored in idle, along with ack and done
    wr(24'h000123, 16'h00A4);
    wr(24'h000200, 16'hA500);
    pulseAck(); pulseDone();
    wr(24'h000004, 16'h1111);
    repeat (2) @(negedge clk);
    chk("R7 no req", progReq, 0);
    chk("R7 no busy", busy, 0);
    chk("R7 bundle untouched", progAddr, 0);

    // R2 quad sequences, low address bits permuted and repeated
    for (int t = 0; t < 8; t++) begin
      base = 24'((t * 24'h13579C + 24'h0A0004) & 24'hFFFFFC);
      for (int i = 0; i < 4; i++) begin
        expA[i] = base | 24'((i * (t + 1) + t) % 4);
        expD[i] = 16'(t * 16'h0101 + i * 16'h1111 + 16'h0F00);
      end
      wr(24'h000555, {8'(t * 37), 8'hA5});
      for (int i = 0; i < 4; i++) begin
        chk("R2 no early req", progReq, 0);
        wr(expA[i], expD[i]);
      end
      chk("R2 req", progReq, 1);
      chk("R2 count", progCount, 4);
      chk("R6 busy on req", busy, 1);
      for (int i = 0; i < 4; i++) begin
        chk("R2 addr slot", progAddr[i*24 +: 24], expA[i]);
        chk("R2 data slot", progData[i*16 +: 16], expD[i]);
      end
      // R5 hold without ack; R8 done before ack ignored
      repeat (t % 3) @(negedge clk);
      if (t[0]) pulseDone();
      chk("R5 req held", progReq, 1);
      chk("R8 still busy", busy, 1);
      chk("R5 data held", progData[63:48], expD[3]);
      pulseAck();
      chk("R5 req ends on ack", progReq, 0);
      chk("R6 busy after ack", busy, 1);
      // R6 writes while busy ignored
      wr(24'h000000, 16'h00A5);
      wr(24'hFFFFFF, 16'h00A0);
      wr(24'h123456, 16'hBEEF);
      chk("R6 addr unchanged", progAddr[23:0], expA[0]);
      chk("R6 data unchanged", progData[15:0], expD[0]);
      chk("R6 busy held", busy, 1);
      pulseDone();
      chk("R6 busy cleared", busy, 0);
      chk("R6 idle no req", progReq, 0);
      chk("R6 count cleared", progCount, 0);
    end

    // R3 single-word program
    for (int t = 0; t < 4; t++) begin
      wr(24'h000777, {8'(t * 91), 8'hA0});
      wr(24'(24'h400003 + t * 24'h010101), 16'(16'hC000 + t));
      chk("R3 req", progReq, 1);
      chk("R3 count", progCount, 1);
      chk("R3 slot0 addr", progAddr[23:0], 24'(24'h400003 + t * 24'h010101));
      chk("R3 slot0 data", progData[15:0], 16'(16'hC000 + t));
      chk("R3 other slots", {progAddr[95:24], progData[63:16]}, 0);
      finishReq();
    end

    // R4 abort sweep: every group bit at every later position
    for (int k = 1; k < 4; k++) begin
      for (int b = 2; b < 24; b++) begin
        base = 24'((b * 24'h05A5A4 + k * 24'h000310) & 24'hFFFFFC);
        wr(24'h0, 16'h00A5);
        for (int i = 0; i < k; i++) wr(base | 24'(i), 16'(16'h1000 + i));
        wr(base ^ (24'h1 << b), 16'h2222);
        chk("R4 abort no req", progReq, 0);
        chk("R4 abort no busy", busy, 0);
        // remaining would-be words must be ignored in idle
        wr(base, 16'h3333);
        chk("R4 stays idle", progReq, 0);
        wr(24'h0, 16'h00A0);
        wr(24'h00ABC0, 16'(b));
        chk("R4 idle after abort", progReq, 1);
        chk("R4 single after abort", progData[15:0], 16'(b));
        finishReq();
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule